// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Clock-Crossing Bridge

This block carries one data word at a time from a source clock domain to an unrelated destination clock domain. On the source side, a word is offered with a valid/ready pair. When it is accepted, the word goes into a holding register that drives a crossing bus, and a request level is inverted.

On the destination side, the request level passes through a multi-flop synchronizer. When the synchronized level differs from the local acknowledge level, the destination copies the crossing bus, raises a one-cycle output strobe and sets its acknowledge to the synchronized request. The acknowledge level crosses back through a second synchronizer. The source offers ready again once its synchronized acknowledge matches its request.

Every edge of the request, rising or falling, carries one word. The crossing bus is never synchronized. It is read only while the control levels show that a word is pending, and the source holds it unchanged for that whole time. Each side has its own clock and its own synchronous active-low reset.

Top module: `hs_cdc_bridge`

## Requirements
- R1: While either side is held in reset, and on leaving reset, `src_ready` is 1 and `dst_valid` is 0. The request level, the acknowledge level and both synchronizer chains clear to 0.
- R2: A word is taken only on a source edge where `src_valid` and `src_ready` are both 1, and that same edge inverts the request level. `src_valid` and `src_data` offered while `src_ready` is 0 are ignored and never delivered.
- R3: The crossing bus loads `src_data` on the accepting edge and keeps that value on every source cycle in which `src_ready` is 0.
- R4: `src_ready` is 1 exactly when the synchronized acknowledge equals the request level. It is 0 on the cycle after an accept and stays 0 until that word has been delivered.
- R5: Each control level passes through SYNC_STAGES flops in series (at least 2) before any logic reads it. The strobe for a word therefore comes no earlier than the third destination edge after the request toggles.
- R6: When the synchronized request differs from the acknowledge level, the destination captures the crossing bus, raises `dst_valid` and sets the acknowledge to the synchronized request, all on the same edge. The acknowledge changes at no other time.
- R7: Every accepted word appears on `dst_data` exactly once, in acceptance order, with the value that was accepted. No strobe appears without a pending word.
- R8: `dst_valid` is high for exactly one destination cycle per word and is never high on two consecutive destination cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain synchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Bridge can accept a word |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain synchronous reset, active low |
| dst_valid | output | 1 | One-cycle strobe marking a delivered word |
| dst_data | output | DATA_W | Delivered word, held until the next delivery |

## Verification
The bench tries three input patterns, each under two clock ratios: a destination slower than the source and a destination faster than it.

- **Sparse pattern.** `src_valid` is held with fixed data until the word is accepted. This shows the basic round trip and the ready timing.
- **Saturating pattern.** `src_valid` stays high and `src_data` changes on every cycle, so the source strobes whenever ready is high. This separates words that were really accepted from words offered while busy, which must vanish.
- **Random pattern.** Valid toggles randomly, so some accepts fall right after ready returns and others after idle gaps. This exposes ordering, duplication and timing faults.

A queue model of accepted words checks each delivery for value, order and minimum synchronizer latency.

// File: rtl/hs_cdc_pkg.sv
// Package: shared constants and types for the two-phase clock-crossing bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package hs_cdc_pkg;

    // Fewest flops a control level may pass through before any logic reads it.
    localparam int unsigned HS_MIN_SYNC = 2;

    // A handshake level. A change in either direction stands for one word.
    typedef logic hs_level_t;

    // True when the two levels show that a word is still outstanding.
    function automatic logic hs_pending(input hs_level_t a, input hs_level_t b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/hs_sync_chain.sv
// Module: hs_sync_chain
// Moves a single-bit level into the clock domain of clk through STAGES flops in series.
// Assumes: STAGES >= 2. The input is a level that changes slowly compared with clk.
// The chain clears to zero under the synchronous active-low reset.
module hs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] stg_q;

    // Shift the incoming level through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/hs_src_side.sv
// Module: hs_src_side
// Source half of the bridge. It accepts a word with valid/ready, loads the crossing
// holding register and inverts the request level on the same edge.
// Assumes: ack_i comes from the destination domain and is only read after synchronization.
// The held word stays unchanged until the acknowledge returns.
module hs_src_side
    import hs_cdc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output hs_level_t         req_o,
    output logic [DATA_W-1:0] bus_o,
    input  hs_level_t         ack_i,
    output hs_level_t         ack_seen_o
);

    hs_level_t         req_q;
    logic [DATA_W-1:0] hold_q;
    hs_level_t         ack_seen;
    logic              take;

    // Bring the destination acknowledge level into this clock domain.
    hs_sync_chain #(.STAGES(STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ack_i),
        .q_sync  (ack_seen)
    );

    // Ready when no word is outstanding; a word is taken on valid and ready together.
    always_comb begin
        in_ready = !hs_pending(req_q, ack_seen);
        take     = in_valid && in_ready;
    end

    // Load the word and invert the request level on the same accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (take) begin
            req_q  <= ~req_q;
            hold_q <= in_data;
        end
    end

    assign req_o      = req_q;
    assign bus_o      = hold_q;
    assign ack_seen_o = ack_seen;

endmodule

// File: rtl/hs_dst_side.sv
// Module: hs_dst_side
// Destination half of the bridge. It watches the synchronized request level. When that
// level differs from acknowledge, it captures the crossing bus, strobes once and mirrors
// the level onto acknowledge.
// Assumes: bus_i is stable whenever the synchronized request differs from acknowledge.
// The output side has no backpressure.
module hs_dst_side
    import hs_cdc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_level_t         req_i,
    input  logic [DATA_W-1:0] bus_i,
    output hs_level_t         ack_o,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output hs_level_t         req_seen_o
);

    hs_level_t         ack_q;
    hs_level_t         req_seen;
    logic              strobe_q;
    logic [DATA_W-1:0] data_q;

    // Bring the source request level into this clock domain.
    hs_sync_chain #(.STAGES(STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_i),
        .q_sync  (req_seen)
    );

    // Capture the word, strobe and mirror the request level when a word is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            strobe_q <= 1'b0;
            data_q   <= '0;
        end else begin
            strobe_q <= 1'b0;
            if (hs_pending(req_seen, ack_q)) begin
                data_q   <= bus_i;
                strobe_q <= 1'b1;
                ack_q    <= req_seen;
            end
        end
    end

    assign ack_o      = ack_q;
    assign out_valid  = strobe_q;
    assign out_data   = data_q;
    assign req_seen_o = req_seen;

endmodule

// File: rtl/hs_cdc_bridge.sv
// Module: hs_cdc_bridge (top)
// Two-phase toggle handshake bridge that carries one word at a time from src_clk to dst_clk.
// Assumes: the two clocks are unrelated. Each reset is synchronous to its own clock and
// active low. SYNC_STAGES values below the minimum are raised to that minimum.
module hs_cdc_bridge
    import hs_cdc_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);

    localparam int unsigned EFF_STAGES =
        (SYNC_STAGES < HS_MIN_SYNC) ? HS_MIN_SYNC : SYNC_STAGES;

    hs_level_t         req_lvl;
    hs_level_t         ack_lvl;
    hs_level_t         req_seen;
    hs_level_t         ack_seen;
    logic [DATA_W-1:0] xbus;

    // Source domain half.
    hs_src_side #(.DATA_W(DATA_W), .STAGES(EFF_STAGES)) u_src (
        .clk        (src_clk),
        .rst_n      (src_rst_n),
        .in_valid   (src_valid),
        .in_data    (src_data),
        .in_ready   (src_ready),
        .req_o      (req_lvl),
        .bus_o      (xbus),
        .ack_i      (ack_lvl),
        .ack_seen_o (ack_seen)
    );

    // Destination domain half.
    hs_dst_side #(.DATA_W(DATA_W), .STAGES(EFF_STAGES)) u_dst (
        .clk        (dst_clk),
        .rst_n      (dst_rst_n),
        .req_i      (req_lvl),
        .bus_i      (xbus),
        .ack_o      (ack_lvl),
        .out_valid  (dst_valid),
        .out_data   (dst_data),
        .req_seen_o (req_seen)
    );

endmodule

// File: rtl/hs_cdc_checker.sv
// Module: hs_cdc_checker
// Protocol properties for hs_cdc_bridge, attached with bind. Each property is clocked
// in the domain that owns the signals it checks.
module hs_cdc_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic              src_valid,
    input logic              src_ready,
    input logic              req_lvl,
    input logic              ack_seen,
    input logic [DATA_W-1:0] xbus,
    input logic              dst_clk,
    input logic              dst_rst_n,
    input logic              dst_valid,
    input logic              req_seen,
    input logic              ack_lvl
);

    AST_REQ_TOGGLES_ON_ACCEPT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_valid && src_ready) |=> (req_lvl != $past(req_lvl))); // R2

    AST_REQ_HOLDS_OTHERWISE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !(src_valid && src_ready) |=> $stable(req_lvl)); // R2

    AST_BUS_HELD_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !src_ready |=> $stable(xbus)); // R3

    AST_READY_DROPS_AFTER_ACCEPT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_valid && src_ready) |=> !src_ready); // R4

    AST_READY_BLOCKED_UNTIL_ACK: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (req_lvl != ack_seen) |-> !src_ready); // R4

    AST_CAPTURE_ON_PENDING: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (req_seen != ack_lvl) |=> (dst_valid && (ack_lvl == $past(req_seen)))); // R6

    AST_ACK_MOVES_WITH_STROBE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (ack_lvl != $past(ack_lvl)) |-> dst_valid); // R6

    AST_NO_SPURIOUS_STROBE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (req_seen == ack_lvl) |=> !dst_valid); // R7

    AST_STROBE_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |=> !dst_valid); // R8

endmodule

bind hs_cdc_bridge hs_cdc_checker #(.DATA_W(DATA_W)) u_hs_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .req_lvl   (req_lvl),
    .ack_seen  (ack_seen),
    .xbus      (xbus),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_valid (dst_valid),
    .req_seen  (req_seen),
    .ack_lvl   (ack_lvl)
);

// File: tb/tb_hs_cdc_bridge.sv
`timescale 1ns/1ps
// Bench: queue-based reference model of accepted words, checked against every delivery.
module tb_hs_cdc_bridge;

    localparam int DW = 16;
    localparam int MIN_LAT = 3;

    logic          src_clk = 1'b0;
    logic          dst_clk = 1'b0;
    logic          src_rst_n = 1'b0;
    logic          dst_rst_n = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready;
    logic          dst_valid;
    logic [DW-1:0] dst_data;

    real     dst_half = 3.35;
    int      checks = 0;
    int      fails = 0;
    int      n_acc = 0;
    int      n_del = 0;
    int      dst_edges = 0;
    bit      prev_acc = 1'b0;
    bit      prev_dv = 1'b0;
    bit      done = 1'b0;
    logic [DW-1:0] exp_q[$];
    int            t0_q[$];

    hs_cdc_bridge #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_valid (dst_valid),
        .dst_data  (dst_data)
    );

    initial forever #2 src_clk = ~src_clk;
    initial forever #(dst_half) dst_clk = ~dst_clk;
    always @(posedge dst_clk) dst_edges++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Source-side monitor: record accepts; check the ready rule.
    always @(negedge src_clk) begin
        if (src_rst_n && dst_rst_n) begin
            if (prev_acc) check(src_ready == 1'b0, "R4 ready after accept", src_ready, 0);
            if (src_ready) check(n_acc == n_del, "R4 ready with word outstanding", n_acc, n_del);
            prev_acc = src_valid && src_ready;
            if (prev_acc) begin
                exp_q.push_back(src_data);
                t0_q.push_back(dst_edges);
                n_acc++;
            end
        end else begin
            prev_acc = 1'b0;
        end
    end

    // Destination-side monitor: compare each delivery with the model queue.
    always @(negedge dst_clk) begin
        if (src_rst_n && dst_rst_n) begin
            if (dst_valid) begin
                check(!prev_dv, "R8 strobe on consecutive cycles", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 delivery with no accepted word", dst_data, -1);
                end else begin
                    logic [DW-1:0] e;
                    int t0;
                    e  = exp_q.pop_front();
                    t0 = t0_q.pop_front();
                    check(dst_data == e, "R7 R6 delivered value/order", dst_data, e);
                    check(dst_edges - t0 >= MIN_LAT, "R5 synchronizer latency",
                          dst_edges - t0, MIN_LAT);
                end
                n_del++;
            end
            prev_dv = dst_valid;
        end else begin
            prev_dv = 1'b0;
        end
    end

    // Drive one source cycle, 1 ns after the rising edge. mode: 0 sparse, 1 saturate, 2 random.
    task automatic drive(input int mode, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge src_clk);
            #1;
            case (mode)
                0: begin
                    if (!src_valid || prev_acc) begin
                        src_valid = ($urandom_range(0, 3) == 0);
                        src_data  = DW'($urandom);
                    end
                end
                1: begin
                    src_valid = 1'b1;
                    src_data  = src_data + 1'b1;
                end
                default: begin
                    src_valid = $urandom_range(0, 1) == 1;
                    src_data  = DW'($urandom);
                end
            endcase
        end
        @(posedge src_clk);
        #1;
        src_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && n_acc != n_del; i++) @(posedge src_clk);
        repeat (10) @(posedge src_clk);
        @(negedge src_clk);
        check(n_acc == n_del, "R7 every word delivered once", n_del, n_acc);
        check(src_ready == 1'b1, "R4 ready back when idle", src_ready, 1);
    endtask

    initial begin
        // Reset state.
        repeat (6) @(negedge src_clk);
        check(src_ready == 1'b1, "R1 ready during reset", src_ready, 1);
        check(dst_valid == 1'b0, "R1 strobe low during reset", dst_valid, 0);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        repeat (4) @(negedge src_clk);
        check(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
        check(dst_valid == 1'b0, "R1 no strobe after reset", dst_valid, 0);

        // Slow destination, then fast destination.
        for (int ph = 0; ph < 2; ph++) begin
            dst_half = (ph == 0) ? 3.35 : 1.45;
            drive(0, 400);  drain();   // sparse, held data
            drive(1, 400);  drain();   // saturating, R2 ignore while busy
            drive(2, 600);  drain();   // random
        end
        check(n_acc > 100, "R2 words accepted", n_acc, 100);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_del, n_acc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule